// File: doc/BRIEF.md
# Circular Sample Buffer with Watermarks

This block manages two circular sample queues that live inside one shared 256-word memory of 16-bit samples. The input queue is filled by a host writing samples and drained by a compute engine; the output queue is filled by the compute engine and drained by the host. Each queue is placed by an 8-bit base word address and a size of 1 to 255 words. Physical addresses are the base plus a running offset, taken modulo 256, so a queue may straddle the top of the memory.

Each queue carries a fill level and a watermark code. The code selects a threshold of 1, 2, 4 or 8 words. The input side reports "full" once fewer free words remain than the threshold. The output side reports "empty" once fewer unread words remain than the threshold. Host accesses that meet a full input or an empty output are rejected and latch sticky error flags. Enable inputs gate four interrupt causes onto one interrupt line and gate two DMA request lines. A synchronous clear command returns pointers, levels and error flags to zero in a single cycle.

Top module: `sample_ring_buf`

## Requirements
- R1: A clear command (`clr` high at a clock edge), or reset, sets both fill levels to 0, both error flags to 0, and both read and write offsets to 0, so the next sample written is stored at the base address.
- R2: Samples pass through each queue in first-in first-out order, and the offsets wrap from size-1 back to 0, so a queue of size N can be used indefinitely.
- R3: The physical word address is (base + offset) mod 256; one memory is shared, so a queue placed at base 254 stores its third sample at address 0, where the other queue can overwrite it.
- R4: `in_full` is 1 exactly when (in_size - in_level) < 2^in_wm, with in_wm code 0,1,2,3 giving a threshold of 1,2,4,8.
- R5: `out_empty` is 1 exactly when out_level < 2^out_wm, with the same code-to-threshold mapping.
- R6: A host write while `in_full` is 1 is rejected: it stores nothing, leaves `in_level` unchanged and sets `ovf_err`, which stays 1 until clear or reset.
- R7: A host read while `out_empty` is 1 is rejected: it leaves `out_level` and the read offset unchanged and sets `unf_err`, which stays 1 until clear or reset.
- R8: `irq` is the OR of four gated causes: `ien_wr` and not `in_full`; `ien_rd` and not `out_empty`; `ien_ovf` and `ovf_err`; `ien_unf` and `unf_err`.
- R9: `dma_wr_req` equals `dma_wr_en` and not `in_full`; `dma_rd_req` equals `dma_rd_en` and not `out_empty`.
- R10: An engine pop from an input queue holding 0 samples, or an engine push into an output queue holding out_size samples, is ignored with no level, pointer or flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear command |
| in_base | input | 8 | Input queue base word address |
| in_size | input | 8 | Input queue size in words (1..255) |
| in_wm | input | 2 | Input full watermark code |
| out_base | input | 8 | Output queue base word address |
| out_size | input | 8 | Output queue size in words (1..255) |
| out_wm | input | 2 | Output empty watermark code |
| host_wr | input | 1 | Host write strobe to input queue |
| host_wdata | input | 16 | Host write sample |
| host_rd | input | 1 | Host read strobe from output queue |
| host_rdata | output | 16 | Oldest unread output sample |
| eng_pop | input | 1 | Engine pop strobe from input queue |
| eng_rdata | output | 16 | Oldest input sample |
| eng_push | input | 1 | Engine push strobe to output queue |
| eng_wdata | input | 16 | Engine result sample |
| in_level | output | 8 | Samples held in input queue |
| out_level | output | 8 | Samples held in output queue |
| in_full | output | 1 | Input watermark full status |
| out_empty | output | 1 | Output watermark empty status |
| ovf_err | output | 1 | Sticky overflow error |
| unf_err | output | 1 | Sticky underflow error |
| ien_wr | input | 1 | Write interrupt enable |
| ien_rd | input | 1 | Read interrupt enable |
| ien_ovf | input | 1 | Overflow interrupt enable |
| ien_unf | input | 1 | Underflow interrupt enable |
| dma_wr_en | input | 1 | DMA write request enable |
| dma_rd_en | input | 1 | DMA read request enable |
| irq | output | 1 | Combined interrupt |
| dma_wr_req | output | 1 | DMA write request |
| dma_rd_req | output | 1 | DMA read request |

## Verification
Levels, offsets and error flags are registered, so the effect of a strobe or clear is due one edge after it is applied; `in_full`, `out_empty`, `irq`, the DMA requests and both read-data outputs are combinational from that registered state plus the configuration and enables, so they are due in the same cycle the state or enable changes. The bench drives every strobe on the falling edge, lets one rising edge pass, and samples 1 ns later, and it changes enables only between edges before sampling the combinational outputs. Watermark sweeps cover every code against sizes 1 to 12, modelling the accept/reject decision of each access arithmetically.

// File: rtl/sample_ring_buf.sv
module sample_ring_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [7:0]  in_base,
  input  logic [7:0]  in_size,
  input  logic [1:0]  in_wm,
  input  logic [7:0]  out_base,
  input  logic [7:0]  out_size,
  input  logic [1:0]  out_wm,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic        host_rd,
  output logic [15:0] host_rdata,
  input  logic        eng_pop,
  output logic [15:0] eng_rdata,
  input  logic        eng_push,
  input  logic [15:0] eng_wdata,
  output logic [7:0]  in_level,
  output logic [7:0]  out_level,
  output logic        in_full,
  output logic        out_empty,
  output logic        ovf_err,
  output logic        unf_err,
  input  logic        ien_wr,
  input  logic        ien_rd,
  input  logic        ien_ovf,
  input  logic        ien_unf,
  input  logic        dma_wr_en,
  input  logic        dma_rd_en,
  output logic        irq,
  output logic        dma_wr_req,
  output logic        dma_rd_req
);

  logic [15:0] mem [256];
  logic [7:0] in_wo, in_ro, out_wo, out_ro;
  logic [8:0] in_free;
  logic [3:0] in_thr, out_thr;
  logic wr_ok, pop_ok, push_ok, rd_ok;

  assign in_thr  = 4'd1 << in_wm;
  assign out_thr = 4'd1 << out_wm;
  assign in_free = {1'b0, in_size} - {1'b0, in_level};

  assign in_full   = in_free < {5'd0, in_thr};
  assign out_empty = out_level < {4'd0, out_thr};

  assign wr_ok   = host_wr  && !in_full;
  assign pop_ok  = eng_pop  && (in_level != 8'd0);
  assign push_ok = eng_push && (out_level < out_size);
  assign rd_ok   = host_rd  && !out_empty;

  assign eng_rdata  = mem[in_base + in_ro];
  assign host_rdata = mem[out_base + out_ro];

  assign irq = (ien_wr && !in_full) || (ien_rd && !out_empty) ||
               (ien_ovf && ovf_err) || (ien_unf && unf_err);
  assign dma_wr_req = dma_wr_en && !in_full;
  assign dma_rd_req = dma_rd_en && !out_empty;

  function automatic logic [7:0] step(input logic [7:0] off, input logic [7:0] size);
    return (off + 8'd1 >= size) ? 8'd0 : off + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!clr && wr_ok)   mem[in_base + in_wo]   <= host_wdata;
    if (!clr && push_ok) mem[out_base + out_wo] <= eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wo <= '0; in_ro <= '0; out_wo <= '0; out_ro <= '0;
      in_level <= '0; out_level <= '0;
      ovf_err <= 1'b0; unf_err <= 1'b0;
    end else if (clr) begin
      in_wo <= '0; in_ro <= '0; out_wo <= '0; out_ro <= '0;
      in_level <= '0; out_level <= '0;
      ovf_err <= 1'b0; unf_err <= 1'b0;
    end else begin
      if (wr_ok)   in_wo  <= step(in_wo, in_size);
      if (pop_ok)  in_ro  <= step(in_ro, in_size);
      if (push_ok) out_wo <= step(out_wo, out_size);
      if (rd_ok)   out_ro <= step(out_ro, out_size);
      in_level  <= in_level + {7'd0, wr_ok} - {7'd0, pop_ok};
      out_level <= out_level + {7'd0, push_ok} - {7'd0, rd_ok};
      if (host_wr && in_full)   ovf_err <= 1'b1;
      if (host_rd && out_empty) unf_err <= 1'b1;
    end
  end

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_level == 8'd0 && out_level == 8'd0 && !ovf_err && !unf_err));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && in_full && !clr) |=> ovf_err);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clr) |=> ovf_err);

  // R6
  rejected_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && in_full && !eng_pop && !clr) |=> $stable(in_level));

  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_err && !clr) |=> unf_err);

  // R7
  rejected_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && out_empty && !eng_push && !clr) |=> $stable(out_level));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_pop && in_level == 8'd0 && !host_wr && !clr) |=> (in_level == 8'd0));

endmodule

// File: tb/sample_ring_buf_test.sv
`timescale 1ns/1ps
module sample_ring_buf_test;
  logic clk = 0, rst_n = 0, clr = 0;
  logic [7:0] in_base = 0, in_size = 8, out_base = 8'd128, out_size = 8;
  logic [1:0] in_wm = 0, out_wm = 0;
  logic host_wr = 0, host_rd = 0, eng_pop = 0, eng_push = 0;
  logic [15:0] host_wdata = 0, eng_wdata = 0;
  logic [15:0] host_rdata, eng_rdata;
  logic [7:0] in_level, out_level;
  logic in_full, out_empty, ovf_err, unf_err, irq, dma_wr_req, dma_rd_req;
  logic ien_wr = 0, ien_rd = 0, ien_ovf = 0, ien_unf = 0, dma_wr_en = 0, dma_rd_en = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_ring_buf uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic p, input logic q,
                     input logic [15:0] wd, input logic [15:0] ed);
    @(negedge clk);
    host_wr = w; host_rd = r; eng_pop = p; eng_push = q; host_wdata = wd; eng_wdata = ed;
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0; eng_pop = 0; eng_push = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(posedge clk); #1; clr = 0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lvl, thr;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 in_level", in_level, 0);
    chk("R1 out_level", out_level, 0);
    chk("R1 errs", {ovf_err, unf_err}, 0);
    chk("R5 empty at reset", out_empty, 1);
    chk("R4 not full at reset", in_full, 0);

    // R2 FIFO with wrap, size 4 base 10
    in_base = 10; in_size = 4; in_wm = 0;
    do_clr();
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 16'h100 + k[15:0], 0);
    for (int k = 0; k < 3; k++) begin
      chk("R2 order", eng_rdata, 16'h100 + k);
      cyc(0, 0, 1, 0, 0, 0);
    end
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 16'h200 + k[15:0], 0);
    chk("R2 level after wrap fill", in_level, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2 wrapped order", eng_rdata, 16'h200 + k);
      cyc(0, 0, 1, 0, 0, 0);
    end

    // R3 modulo-256 addressing and shared memory
    in_base = 254; in_size = 4; out_base = 0; out_size = 4; out_wm = 0;
    do_clr();
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 16'hA0 + k[15:0], 0);
    cyc(0, 0, 0, 1, 0, 16'hEEEE);
    chk("R3 alias via output", host_rdata, 16'hEEEE);
    chk("R3 addr 254", eng_rdata, 16'hA0); cyc(0, 0, 1, 0, 0, 0);
    chk("R3 addr 255", eng_rdata, 16'hA1); cyc(0, 0, 1, 0, 0, 0);
    chk("R3 addr 0 overwritten", eng_rdata, 16'hEEEE);
    in_base = 0; out_base = 8'd128;

    // R4 / R6 sweep on input side
    for (int wm = 0; wm < 4; wm++)
      for (int sz = 1; sz <= 12; sz++) begin
        in_wm = wm[1:0]; in_size = sz[7:0]; thr = 1 << wm;
        do_clr();
        lvl = 0;
        chk("R4 full initial", in_full, (sz < thr) ? 1 : 0);
        for (int k = 0; k <= sz; k++) begin
          logic rej;
          rej = (sz - lvl) < thr;
          cyc(1, 0, 0, 0, k[15:0], 0);
          if (!rej) lvl++;
          chk("R4 level", in_level, lvl);
          chk("R4 full", in_full, ((sz - lvl) < thr) ? 1 : 0);
          if (rej) chk("R6 ovf", ovf_err, 1);
        end
        chk("R6 sticky ovf", ovf_err, 1);
      end

    // R5 / R7 / R10 sweep on output side
    for (int wm = 0; wm < 4; wm++)
      for (int sz = 1; sz <= 12; sz++) begin
        int rdk;
        out_wm = wm[1:0]; out_size = sz[7:0]; thr = 1 << wm;
        do_clr();
        lvl = 0;
        cyc(0, 1, 0, 0, 0, 0);
        chk("R7 unf on empty", unf_err, 1);
        chk("R7 level held", out_level, 0);
        for (int k = 0; k <= sz; k++) begin
          cyc(0, 0, 0, 1, 0, 16'h300 + k[15:0]);
          if (lvl < sz) lvl++;
          chk("R10 push level", out_level, lvl);
          chk("R5 empty", out_empty, (lvl < thr) ? 1 : 0);
        end
        rdk = 0;
        for (int k = 0; k <= sz; k++) begin
          logic rej;
          rej = lvl < thr;
          if (!rej) chk("R2 output order", host_rdata, 16'h300 + rdk);
          cyc(0, 1, 0, 0, 0, 0);
          if (!rej) begin lvl--; rdk++; end
          chk("R7 level", out_level, lvl);
          chk("R5 empty after read", out_empty, (lvl < thr) ? 1 : 0);
        end
        chk("R7 sticky unf", unf_err, 1);
      end

    // R10 pop on empty input ignored
    in_size = 4; in_wm = 0; out_size = 4; out_wm = 0;
    do_clr();
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10 pop empty level", in_level, 0);
    cyc(1, 0, 0, 0, 16'h5A5A, 0);
    chk("R10 pointer unmoved", eng_rdata, 16'h5A5A);

    // R1 clear mid-stream
    cyc(1, 0, 0, 0, 16'h1111, 0);
    cyc(0, 1, 0, 0, 0, 0);
    do_clr();
    chk("R1 clr levels", {in_level, out_level}, 0);
    chk("R1 clr errs", {ovf_err, unf_err}, 0);
    cyc(1, 0, 0, 0, 16'h7777, 0);
    chk("R1 restart at base", eng_rdata, 16'h7777);

    // R8 / R9: in level 1 of 4 (not full), out empty, no errors
    #1;
    ien_wr = 1; #1; chk("R8 wr irq", irq, 1); ien_wr = 0;
    ien_rd = 1; #1; chk("R8 rd irq masked by empty", irq, 0); ien_rd = 0;
    ien_ovf = 1; ien_unf = 1; #1; chk("R8 no err irq", irq, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 unf irq", irq, 1); ien_unf = 0; #1;
    chk("R8 ovf gated off", irq, 0);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0);
    chk("R8 ovf irq", irq, 1); ien_ovf = 0;
    dma_wr_en = 1; #1; chk("R9 wr req off when full", dma_wr_req, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R9 wr req", dma_wr_req, 1);
    dma_wr_en = 0; #1; chk("R9 wr req gated", dma_wr_req, 0);
    dma_rd_en = 1; #1; chk("R9 rd req empty", dma_rd_req, 0);
    cyc(0, 0, 0, 1, 0, 16'h42);
    chk("R9 rd req", dma_rd_req, 1);
    ien_rd = 1; #1; chk("R8 rd irq", irq, 1);
    dma_rd_en = 0; ien_rd = 0; #1;
    chk("R9 rd req gated", dma_rd_req, 0);
    chk("R8 all disabled", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule